// File: doc/BRIEF.md
# Shifter Operand Generator with Carry

This unit builds the second ALU operand for a 32-bit data-processing datapath and the carry-out of the shifter that goes with it. It is purely combinational. The unit has three sources for the operand. The first takes an 8-bit constant from a 12-bit immediate field and rotates it. The second moves a register operand by a 5-bit immediate amount. The third moves the register operand by an amount held in a second register. The movement is a logical right shift or a rotate right. There is also an explicit rotate right through the carry flag.

The datapath feeds the unit the operand value, both possible shift amounts, a 2-bit kind select, a bit that picks the immediate or the register amount, and the current carry flag. It takes back the 32-bit operand and the carry-out. Amounts of zero, exactly 32 and above 32 each follow their own rule. An immediate rotate amount of zero stands for a one-bit rotate through the carry.

Top module: `opnd_shifter`

## Requirements
- R1: With kind_i = 00 the result is imm12_i[7:0], zero-extended to 32 bits and rotated right by twice imm12_i[11:8].
- R2: With kind_i = 00 the carry-out is carry_i when imm12_i[11:8] is zero. Otherwise it is bit 31 of the rotated result.
- R3: With kind_i = 01 and amt_from_reg_i = 0, an amount n = shamt_imm_i from 1 to 31 gives opnd_i >> n and carry-out opnd_i[n-1].
- R4: With kind_i = 01 and amt_from_reg_i = 0, shamt_imm_i = 0 means a shift by 32. The result is 0 and the carry-out is opnd_i[31].
- R5: With kind_i = 01 and amt_from_reg_i = 1, an amount byte shamt_reg_i[7:0] of 0 passes opnd_i through with carry-out carry_i. An amount from 1 to 31 behaves as in R3.
- R6: With kind_i = 01 and amt_from_reg_i = 1, an amount byte of exactly 32 gives 0 with carry-out opnd_i[31]. An amount byte above 32 gives 0 with carry-out 0.
- R7: With kind_i = 10 and amt_from_reg_i = 0, shamt_imm_i = 0 gives {carry_i, opnd_i[31:1]} with carry-out opnd_i[0]. An amount n from 1 to 31 rotates opnd_i right by n with carry-out opnd_i[n-1].
- R8: With kind_i = 10 and amt_from_reg_i = 1, an amount byte of 0 passes opnd_i through with carry-out carry_i.
- R9: With kind_i = 10 and amt_from_reg_i = 1, a nonzero amount byte whose bits 4:0 are zero passes opnd_i through with carry-out opnd_i[31]. Any other nonzero byte rotates opnd_i right by bits 4:0 (n), with carry-out opnd_i[n-1].
- R10: With kind_i = 11 the result is {carry_i, opnd_i[31:1]} and the carry-out is opnd_i[0], whatever the amounts and amt_from_reg_i.
- R11: Bits 31:8 of shamt_reg_i have no effect on either output.
- R12: With kind_i = 00, opnd_i, both amounts and amt_from_reg_i have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Register operand to shift or rotate |
| imm12_i | input | 12 | Immediate field: rotate count in 11:8, constant in 7:0 |
| shamt_imm_i | input | 5 | Immediate shift amount |
| shamt_reg_i | input | 32 | Register holding the shift amount; only bits 7:0 count |
| amt_from_reg_i | input | 1 | 1 selects the register amount, 0 the immediate amount |
| kind_i | input | 2 | 00 rotated constant, 01 logical right, 10 rotate right, 11 rotate through carry |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifter operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The embedded checks assume that every input is a defined 0 or 1 after each change. They also assume that kind_i takes only its four codes and that results are read only once the combinational paths have settled. The stimulus meets these assumptions. It drives every input on a full clock edge and reads the outputs half a period later, so the checks never see a value in mid-change. The sweeps cover amounts 0 to 40, together with bytes such as 64, 96 and 255 that stress the low-five-bit rule. Random values fill the bits above the amount byte and the inputs that the selected kind ignores.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int OPW  = 32;             // operand width
  localparam int SHW  = $clog2(OPW);    // in-range shift index width
  localparam int AMTW = 8;              // significant bits of a register amount
  localparam int CSTW = 8;              // immediate constant width
  localparam int RCW  = 4;              // immediate rotate count width
  localparam int IMMW = CSTW + RCW;

  typedef enum logic [1:0] {
    K_ROTIMM = 2'b00,
    K_LSR    = 2'b01,
    K_ROR    = 2'b10,
    K_RRX    = 2'b11
  } op_kind_e;

  // rotate right by n; n = 0 leaves the value unchanged
  function automatic logic [OPW-1:0] rot_right(input logic [OPW-1:0] v,
                                               input logic [SHW-1:0] n);
    return (v >> n) | (v << (OPW - int'(n)));
  endfunction

  // one-bit rotate through the carry: {carry, value} result
  function automatic logic [OPW:0] thru_carry(input logic [OPW-1:0] v, input logic c);
    return {v[0], c, v[OPW-1:1]};
  endfunction
endpackage

// File: rtl/sop_rotimm.sv
module sop_rotimm
  import sop_pkg::*;
#(
  parameter int W  = OPW,
  parameter int CW = CSTW,
  parameter int RW = RCW
) (
  input  logic [CW+RW-1:0] field_i,
  input  logic             c_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);
  localparam int SW = $clog2(W);

  logic [RW-1:0] cnt;
  logic [SW-1:0] amt;
  logic          no_rot;

  assign cnt    = field_i[CW+RW-1:CW];
  assign amt    = SW'({cnt, 1'b0});
  assign no_rot = (cnt == '0);
  assign res_o  = rot_right(W'(field_i[CW-1:0]), amt);
  assign carry_o = no_rot ? c_i : res_o[W-1];

  always_comb begin
    AST_ROTIMM_BITS_KEPT: assert ($countones(res_o) == $countones(field_i[CW-1:0])); // R1
    if (no_rot)
      AST_ROTIMM_IDENTITY: assert (res_o == W'(field_i[CW-1:0]) && carry_o == c_i); // R2
  end
endmodule

// File: rtl/sop_lsr.sv
module sop_lsr
  import sop_pkg::*;
#(
  parameter int W  = OPW,
  parameter int AW = AMTW
) (
  input  logic [W-1:0]          opnd_i,
  input  logic [$clog2(W)-1:0]  amt_imm_i,
  input  logic [AW-1:0]         amt_reg_i,
  input  logic                  use_reg_i,
  input  logic                  c_i,
  output logic [W-1:0]          res_o,
  output logic                  carry_o
);
  localparam int SW = $clog2(W);

  logic [AW-1:0] n;
  logic          is_zero, is_full, is_over, in_range;

  // an immediate amount of zero encodes a shift by the full width
  assign n        = use_reg_i ? amt_reg_i
                  : ((amt_imm_i == '0) ? AW'(W) : AW'(amt_imm_i));
  assign is_zero  = (n == '0);
  assign is_full  = (n == AW'(W));
  assign is_over  = (n > AW'(W));
  assign in_range = !is_zero && !is_full && !is_over;

  always_comb begin
    if (is_zero) begin
      res_o   = opnd_i;
      carry_o = c_i;
    end else if (in_range) begin
      res_o   = opnd_i >> n[SW-1:0];
      carry_o = opnd_i[n[SW-1:0] - 1'b1];
    end else if (is_full) begin
      res_o   = '0;
      carry_o = opnd_i[W-1];
    end else begin
      res_o   = '0;
      carry_o = 1'b0;
    end
  end

  always_comb begin
    if (is_full || is_over)
      AST_LSR_WIDE_CLEARS: assert (res_o == '0); // R6
    if (in_range)
      AST_LSR_MSB_FILL: assert (res_o[W-1] == 1'b0); // R3
    if (!use_reg_i)
      AST_LSR_IMM_NEVER_PASS: assert (!is_zero && !is_over); // R4
  end
endmodule

// File: rtl/sop_ror.sv
module sop_ror
  import sop_pkg::*;
#(
  parameter int W  = OPW,
  parameter int AW = AMTW
) (
  input  logic [W-1:0]          opnd_i,
  input  logic [$clog2(W)-1:0]  amt_imm_i,
  input  logic [AW-1:0]         amt_reg_i,
  input  logic                  use_reg_i,
  input  logic                  c_i,
  output logic [W-1:0]          res_o,
  output logic                  carry_o
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] n;
  logic          imm_rrx, reg_pass_c, reg_full_turn, rotating;
  logic [W:0]    rrx_val;

  assign n             = use_reg_i ? amt_reg_i[SW-1:0] : amt_imm_i;
  assign imm_rrx       = !use_reg_i && (amt_imm_i == '0);
  assign reg_pass_c    = use_reg_i && (amt_reg_i == '0);
  assign reg_full_turn = use_reg_i && (amt_reg_i != '0) && (n == '0);
  assign rotating      = !imm_rrx && !reg_pass_c && !reg_full_turn;
  assign rrx_val       = thru_carry(opnd_i, c_i);

  always_comb begin
    if (imm_rrx) begin
      res_o   = rrx_val[W-1:0];
      carry_o = rrx_val[W];
    end else if (reg_pass_c) begin
      res_o   = opnd_i;
      carry_o = c_i;
    end else if (reg_full_turn) begin
      res_o   = opnd_i;
      carry_o = opnd_i[W-1];
    end else begin
      res_o   = rot_right(opnd_i, n);
      carry_o = opnd_i[n - 1'b1];
    end
  end

  always_comb begin
    if (rotating || reg_full_turn)
      AST_ROR_CARRY_MSB: assert (carry_o == res_o[W-1]); // R9
    if (!imm_rrx)
      AST_ROR_BITS_KEPT: assert ($countones(res_o) == $countones(opnd_i)); // R7
    if (imm_rrx)
      AST_ROR_ZERO_IS_RRX: assert (carry_o == opnd_i[0]); // R7
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import sop_pkg::*;
#(
  parameter int W  = OPW,
  parameter int AW = AMTW,
  parameter int CW = CSTW,
  parameter int RW = RCW
) (
  input  logic [W-1:0]          opnd_i,
  input  logic [CW+RW-1:0]      imm12_i,
  input  logic [$clog2(W)-1:0]  shamt_imm_i,
  input  logic [W-1:0]          shamt_reg_i,
  input  logic                  amt_from_reg_i,
  input  logic [1:0]            kind_i,
  input  logic                  carry_i,
  output logic [W-1:0]          result_o,
  output logic                  carry_o
);
  op_kind_e      kind;
  logic [AW-1:0] amt_byte;
  logic          unused_amt_hi;
  logic [W-1:0]  ri_res, lsr_res, ror_res;
  logic          ri_c, lsr_c, ror_c;
  logic [W:0]    rrx_val;

  assign kind          = op_kind_e'(kind_i);
  assign amt_byte      = shamt_reg_i[AW-1:0];
  assign unused_amt_hi = ^shamt_reg_i[W-1:AW];
  assign rrx_val       = thru_carry(opnd_i, carry_i);

  sop_rotimm #(.W(W), .CW(CW), .RW(RW)) u_rotimm (
    .field_i(imm12_i), .c_i(carry_i), .res_o(ri_res), .carry_o(ri_c)
  );

  sop_lsr #(.W(W), .AW(AW)) u_lsr (
    .opnd_i(opnd_i), .amt_imm_i(shamt_imm_i), .amt_reg_i(amt_byte),
    .use_reg_i(amt_from_reg_i), .c_i(carry_i), .res_o(lsr_res), .carry_o(lsr_c)
  );

  sop_ror #(.W(W), .AW(AW)) u_ror (
    .opnd_i(opnd_i), .amt_imm_i(shamt_imm_i), .amt_reg_i(amt_byte),
    .use_reg_i(amt_from_reg_i), .c_i(carry_i), .res_o(ror_res), .carry_o(ror_c)
  );

  always_comb begin
    unique case (kind)
      K_ROTIMM: begin result_o = ri_res;          carry_o = ri_c;       end
      K_LSR:    begin result_o = lsr_res;         carry_o = lsr_c;      end
      K_ROR:    begin result_o = ror_res;         carry_o = ror_c;      end
      default:  begin result_o = rrx_val[W-1:0];  carry_o = rrx_val[W]; end
    endcase
  end

  always_comb begin
    if (kind == K_RRX)
      AST_RRX_SHAPE: assert (carry_o == opnd_i[0] && result_o[W-2:0] == opnd_i[W-1:1]
                             && result_o[W-1] == carry_i); // R10
    if (kind == K_ROTIMM)
      AST_ROTIMM_HIGH_CLEAN: assert ($countones(result_o) <= CW); // R12
  end
endmodule

// File: tb/sim_opnd_shifter.sv
`timescale 1ns/1ps
module sim_opnd_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd, sreg;
  logic [11:0] imm12;
  logic [4:0]  simm;
  logic        from_reg, cin;
  logic [1:0]  kind;
  logic [31:0] result;
  logic        cout;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        cy;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  opnd_shifter u0 (
    .opnd_i(opnd), .imm12_i(imm12), .shamt_imm_i(simm), .shamt_reg_i(sreg),
    .amt_from_reg_i(from_reg), .kind_i(kind), .carry_i(cin),
    .result_o(result), .carry_o(cout)
  );

  // reference: 64-bit doubled words for rotates, 33-bit window for shifts
  function automatic logic [32:0] model(input logic [1:0] k, input logic sel,
      input logic [31:0] op, input logic [11:0] f, input logic [4:0] ia,
      input logic [31:0] ra, input logic c);
    logic [63:0] dbl;
    logic [32:0] win;
    int          amt;
    logic [31:0] r;
    case (k)
      2'b00: begin
        dbl = {24'd0, f[7:0], 24'd0, f[7:0]} >> (2 * f[11:8]);
        r   = dbl[31:0];
        return {(f[11:8] == 0) ? c : r[31], r};
      end
      2'b01: begin
        amt = sel ? int'(ra[7:0]) : ((ia == 0) ? 32 : int'(ia));
        if (amt == 0) return {c, op};
        if (amt > 32) return 33'd0;
        win = {op, 1'b0} >> amt;
        return {win[0], win[32:1]};
      end
      2'b10: begin
        if (!sel && ia == 0) return {op[0], c, op[31:1]};
        if (sel && ra[7:0] == 0) return {c, op};
        amt = sel ? int'(ra[4:0]) : int'(ia);
        if (amt == 0) return {op[31], op};
        dbl = {op, op} >> amt;
        return {dbl[31], dbl[31:0]};
      end
      default: return {op[0], c, op[31:1]};
    endcase
  endfunction

  task automatic drive(input logic [1:0] k, input logic sel, input logic [31:0] op,
      input logic [11:0] f, input logic [4:0] ia, input logic [31:0] ra,
      input logic c, input string tag);
    exp_t e;
    logic [32:0] m;
    @(posedge clk);
    kind = k; from_reg = sel; opnd = op; imm12 = f; simm = ia; sreg = ra; cin = c;
    m = model(k, sel, op, f, ia, ra, c);
    e.res = m[31:0]; e.cy = m[32]; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare half a period after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (result !== e.res || cout !== e.cy) begin
          n_bad++;
          $display("FAIL %s: actual res=%h c=%b expected res=%h c=%b (kind=%b sel=%b op=%h f=%h ia=%0d ra=%h cin=%b)",
                   e.tag, result, cout, e.res, e.cy, kind, from_reg, opnd, imm12, simm, sreg, cin);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=still running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat [4];
    pat[0] = 32'h8000_0001; pat[1] = 32'hDEAD_BEEF; pat[2] = 32'h7FFF_FFFE; pat[3] = 32'h0000_0000;
    opnd = '0; sreg = '0; imm12 = '0; simm = '0; from_reg = 1'b0; kind = 2'b00; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs: all zero, constant 0 with no rotate
    drive(2'b00, 1'b0, 32'd0, 12'h000, 5'd0, 32'd0, 1'b0, "R2 idle");

    // R1 R2: all sixteen rotate counts, several constants, both carries
    for (int cnt = 0; cnt < 16; cnt++) begin
      drive(2'b00, 1'b0, 32'd0, {cnt[3:0], 8'hFF}, 5'd0, 32'd0, 1'b1, "R1 const FF");
      drive(2'b00, 1'b0, 32'd0, {cnt[3:0], 8'h81}, 5'd0, 32'd0, 1'b0, "R2 const 81");
      drive(2'b00, 1'b0, 32'd0, {cnt[3:0], 8'h02}, 5'd0, 32'd0, 1'b1, "R2 const 02");
    end

    // R12: other inputs random under kind 00
    for (int i = 0; i < 20; i++)
      drive(2'b00, i[0], $urandom, 12'h3C5, 5'($urandom), $urandom, 1'b0, "R12 ignore");

    // R3 R4: immediate logical shift, amounts 0..31
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 32; a++)
        drive(2'b01, 1'b0, pat[p], 12'h0, a[4:0], 32'd0, a[0],
              (a == 0) ? "R4 lsr imm zero" : "R3 lsr imm");

    // R5 R6 R11: register logical shift, amounts 0..40 and large bytes
    for (int p = 0; p < 4; p++)
      for (int a = 0; a <= 40; a++)
        drive(2'b01, 1'b1, pat[p], 12'h0, 5'd0, {24'($urandom), a[7:0]}, ~a[0],
              (a <= 31) ? "R5 R11 lsr reg" : "R6 R11 lsr reg big");
    drive(2'b01, 1'b1, 32'hFFFF_FFFF, 12'h0, 5'd0, 32'h0000_00FF, 1'b1, "R6 lsr byte 255");
    drive(2'b01, 1'b1, 32'hFFFF_FFFF, 12'h0, 5'd0, 32'hFFFF_FF00, 1'b1, "R11 upper bits only");

    // R7: immediate rotate, amounts 0..31
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 32; a++)
        drive(2'b10, 1'b0, pat[p], 12'h0, a[4:0], 32'd0, a[1], "R7 ror imm");

    // R8 R9: register rotate, amounts 0..40 plus multiples of 32
    for (int p = 0; p < 4; p++)
      for (int a = 0; a <= 40; a++)
        drive(2'b10, 1'b1, pat[p], 12'h0, 5'd0, {24'($urandom), a[7:0]}, a[0],
              (a == 0) ? "R8 ror reg zero" : "R9 ror reg");
    drive(2'b10, 1'b1, 32'h8000_0000, 12'h0, 5'd0, 32'h0000_0040, 1'b0, "R9 ror byte 64");
    drive(2'b10, 1'b1, 32'h0000_0001, 12'h0, 5'd0, 32'h0000_0060, 1'b1, "R9 ror byte 96");
    drive(2'b10, 1'b1, 32'h1234_5678, 12'h0, 5'd0, 32'h0000_00FF, 1'b0, "R9 ror byte 255");
    drive(2'b10, 1'b1, 32'h1234_5678, 12'h0, 5'd0, 32'hABCD_EF00, 1'b1, "R8 R11 upper bits only");

    // R10: explicit rotate through carry under random amounts
    for (int i = 0; i < 24; i++)
      drive(2'b11, i[1], $urandom, 12'($urandom), 5'($urandom), $urandom, i[0], "R10 rrx");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule